// File: doc/BRIEF.md
# Capture/Compare Free-Running Timer

This block is a 16-bit up-counter that advances by one on every clock cycle in which a prescaled count-enable strobe is high. It has one input-capture channel and two output-compare channels, A and B. A rising or falling transition on an asynchronous capture pin copies the live counter value into a capture register. Each compare channel watches the counter. When the count moves off the value held in that channel's compare register, the channel emits a one-cycle match pulse.

Software reaches the counter, the capture register, both compare registers, a status word and a control word through a simple select/write register port. The status word holds three sticky flags: capture, compare A and compare B. Writing 1 to a flag bit clears it. The control word selects the capture edge and enables each flag onto a level interrupt output.

A compare match fires only in the cycle in which the counter actually leaves the matching value. It therefore fires once per counter value, however long the counter dwells there and however often the compare register is rewritten during that time.

Top module: `cap_cmp_timer`

## Requirements
- R1: The counter increases by exactly one after each clock edge at which `cnt_en` is high and no counter write occurs. It holds when `cnt_en` is low. It wraps from 0xFFFF to 0x0000.
- R2: A bus write to the counter address (0) loads `bus_wdata` at that edge and overrides any increment in the same cycle.
- R3: After reset the counter and capture register read 0x0000, both compare registers (addresses 1 and 2) read 0xFFFF, and the status word (address 4) and `irq` are 0.
- R4: A capture transition of the selected polarity on `cap_in` is detected through a two-stage synchroniser. The capture register (address 3) and the capture flag (status bit 0) are updated together at the third clock edge after the pin changes. The value captured is the counter value in the cycle just before that edge. A capture event overrides a bus write to the capture register.
- R5: Control bit 0 selects the edge: 1 means rising and 0 means falling. A transition of the other polarity sets no flag and leaves the capture register unchanged.
- R6: `match_a` (`match_b`) is high, combinationally, only in a cycle where `cnt_en` is high, no counter write occurs, and the counter equals compare register A (B).
- R7: Each match sets its own flag at the clock edge that ends the match cycle: status bit 1 for A and bit 2 for B. The two channels are independent.
- R8: Writing the status address clears each flag whose data bit is 1, and leaves flags whose data bit is 0 unchanged. A set event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some flag is set and its enable is set. The enables sit at control bits 1 (capture), 2 (compare A) and 3 (compare B).
- R10: Rewriting a compare register to the held counter value while the counter is stopped produces no match pulse and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Prescaled count-enable strobe |
| cap_in | input | 1 | Asynchronous capture pin |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, valid with `bus_sel` |
| bus_addr | input | 3 | Register address: 0 counter, 1 compare A, 2 compare B, 3 capture, 4 status, 5 control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| match_a | output | 1 | Compare A match pulse |
| match_b | output | 1 | Compare B match pulse |
| irq | output | 1 | Level interrupt |

## Verification
Match pulses are combinational, so the bench checks them in the same cycle it drives `cnt_en`, before the next edge. Counter, flag and register contents are read back one edge after the write or event that changes them. A capture is due at the third edge after the pin moves, so the flag is checked to be clear after two edges and set after three. The expected captured value is the counter the bench recorded after the second edge. The random phase predicts every cycle's match outputs from a bench-side model of the counter and compare values.

// File: rtl/cct_pkg.sv
package cct_pkg;

    // Register addresses of the software port
    typedef enum logic [2:0] {
        REG_CNT  = 3'd0,
        REG_CMPA = 3'd1,
        REG_CMPB = 3'd2,
        REG_CAP  = 3'd3,
        REG_STAT = 3'd4,
        REG_CTRL = 3'd5
    } reg_addr_e;

    // Flag bit positions in the status word and enable positions (shifted by one) in control
    localparam int unsigned FLAG_CAP = 0;
    localparam int unsigned FLAG_CMP0 = 1;

endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise_sel,
    output logic edge_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // newest synchronised sample against the one before it
    assign edge_o = rise_sel ? ( sh_q[STAGES-1] & ~sh_q[STAGES])
                             : (~sh_q[STAGES-1] &  sh_q[STAGES]);
endmodule

// File: rtl/cct_cmp_unit.sv
module cct_cmp_unit #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         adv,
    output logic         hit
);
    // fires only in the cycle the counter leaves the matching value
    assign hit = adv && (cnt == cmp);
endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
    import cct_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cap_in,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             match_a,
    output logic             match_b,
    output logic             irq
);
    localparam int unsigned NCMP   = 2;
    localparam int unsigned NFLAG  = NCMP + 1;
    localparam int unsigned CTRL_W = NFLAG + 1;
    localparam int unsigned CMP0_A = int'(REG_CMPA);

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [CNT_W-1:0]            cap;
        logic [NCMP-1:0][CNT_W-1:0]  cmp;
        logic [NFLAG-1:0]            flag;
        logic [NFLAG-1:0]            ien;
        logic                        edge_rise;
    } st_t;

    st_t st_d, st_q;

    logic            wr_en, cnt_wr, adv, cap_evt;
    logic [NCMP-1:0] hit;

    assign wr_en  = bus_sel && bus_wr;
    assign cnt_wr = wr_en && (bus_addr == REG_CNT);
    assign adv    = cnt_en && !cnt_wr;

    cct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (cap_in),
        .rise_sel (st_q.edge_rise),
        .edge_o   (cap_evt)
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        cct_cmp_unit #(.W(CNT_W)) u_cmp (
            .cnt (st_q.cnt),
            .cmp (st_q.cmp[g]),
            .adv (adv),
            .hit (hit[g])
        );
    end

    always_comb begin
        st_d = st_q;

        // counter: bus write beats the strobe
        if (cnt_wr)      st_d.cnt = bus_wdata;
        else if (cnt_en) st_d.cnt = st_q.cnt + 1'b1;

        for (int i = 0; i < NCMP; i++) begin
            if (wr_en && (bus_addr == 3'(CMP0_A + i))) st_d.cmp[i] = bus_wdata;
        end

        if (wr_en && (bus_addr == REG_CAP)) st_d.cap = bus_wdata;
        if (cap_evt)                        st_d.cap = st_q.cnt;

        if (wr_en && (bus_addr == REG_CTRL)) begin
            st_d.edge_rise = bus_wdata[0];
            st_d.ien       = bus_wdata[CTRL_W-1:1];
        end

        // write-one-to-clear first, then set events on top
        if (wr_en && (bus_addr == REG_STAT)) st_d.flag = st_q.flag & ~bus_wdata[NFLAG-1:0];
        if (cap_evt) st_d.flag[FLAG_CAP] = 1'b1;
        for (int i = 0; i < NCMP; i++) begin
            if (hit[i]) st_d.flag[FLAG_CMP0 + i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cmp <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CNT:  bus_rdata = st_q.cnt;
            REG_CMPA: bus_rdata = st_q.cmp[0];
            REG_CMPB: bus_rdata = st_q.cmp[1];
            REG_CAP:  bus_rdata = st_q.cap;
            REG_STAT: bus_rdata[NFLAG-1:0]  = st_q.flag;
            REG_CTRL: bus_rdata[CTRL_W-1:0] = {st_q.ien, st_q.edge_rise};
            default:  bus_rdata = '0;
        endcase
    end

    assign match_a = hit[0];
    assign match_b = hit[1];
    assign irq     = |(st_q.flag & st_q.ien);

    // taps for the bound checker
    logic [CNT_W-1:0] cnt_w;
    logic [NFLAG-1:0] flag_w;
    logic             cnt_wr_w;
    assign cnt_w    = st_q.cnt;
    assign flag_w   = st_q.flag;
    assign cnt_wr_w = cnt_wr;

endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_en,
    input logic          cnt_wr,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] wdata,
    input logic [2:0]    flags,
    input logic          match_a,
    input logic          match_b,
    input logic          irq
);
    p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_wr) |=> (cnt == CW'($past(cnt) + 1'b1)));

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_wr && (cnt == {CW{1'b1}})) |=> (cnt == '0));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_wr) |=> $stable(cnt));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata)));

    p_match_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a || match_b) |-> (cnt_en && !cnt_wr));

    p_flag_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |=> flags[1]);

    p_flag_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_b |=> flags[2]);

    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));
endmodule

bind cap_cmp_timer cct_checker #(.CW(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .cnt_wr  (cnt_wr_w),
    .cnt     (cnt_w),
    .wdata   (bus_wdata),
    .flags   (flag_w),
    .match_a (match_a),
    .match_b (match_b),
    .irq     (irq)
);

// File: tb/cap_cmp_timer_test.sv
`timescale 1ns/1ps
module cap_cmp_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, cap_in = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        match_a, match_b, irq;

    int checks = 0, fails = 0;
    logic [15:0] exp_cnt = 16'd0, exp_ca = 16'hFFFF, exp_cb = 16'hFFFF;
    logic [15:0] rv, snap;

    always #5 clk = ~clk;

    cap_cmp_timer uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_in(cap_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .match_a(match_a), .match_b(match_b), .irq(irq)
    );

    function automatic logic pred_match(logic en, logic cwr, logic [15:0] c, logic [15:0] r);
        return en && !cwr && (c == r);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle's inputs (called just after an edge)
    task automatic drive(logic en, logic wr, logic [2:0] a, logic [15:0] d);
        cnt_en = en; bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
    endtask

    // advance one edge, update bench model, return inputs to idle
    task automatic edge_step();
        logic cwr;
        cwr = bus_wr && bus_sel && (bus_addr == 3'd0);
        @(posedge clk);
        if (cwr) exp_cnt = bus_wdata;
        else if (cnt_en) exp_cnt = exp_cnt + 16'd1;
        if (bus_wr && bus_sel && bus_addr == 3'd1) exp_ca = bus_wdata;
        if (bus_wr && bus_sel && bus_addr == 3'd2) exp_cb = bus_wdata;
        #1;
        cnt_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        drive(1'b0, 1'b1, a, d);
        edge_step();
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic tick(logic en);
        drive(en, 1'b0, 3'd0, 16'd0);
        edge_step();
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R3 reset values
        rd(3'd0, rv); check("R3 cnt", rv, 16'h0000);
        rd(3'd1, rv); check("R3 cmpA", rv, 16'hFFFF);
        rd(3'd2, rv); check("R3 cmpB", rv, 16'hFFFF);
        rd(3'd3, rv); check("R3 cap", rv, 16'h0000);
        rd(3'd4, rv); check("R3 stat", rv, 16'h0000);
        check("R3 irq", irq, 1'b0);

        // R1 counting and holding
        repeat (5) tick(1'b1);
        rd(3'd0, rv); check("R1 count5", rv, 16'd5);
        repeat (3) tick(1'b0);
        rd(3'd0, rv); check("R1 hold", rv, 16'd5);

        // R2 write overrides strobe
        drive(1'b1, 1'b1, 3'd0, 16'h1234);
        edge_step();
        rd(3'd0, rv); check("R2 load", rv, 16'h1234);

        // R6/R7/R10 compare timing
        wr(3'd1, 16'h1236);
        wr(3'd2, 16'h1238);
        drive(1'b1, 1'b0, 3'd0, 16'd0);
        check("R6 no early match", match_a, 1'b0);
        edge_step();
        tick(1'b1);                       // counter now 0x1236
        drive(1'b0, 1'b0, 3'd0, 16'd0);
        check("R6 held no match", match_a, 1'b0);
        edge_step();
        wr(3'd1, 16'h1236);               // R10 rewrite while held
        tick(1'b0);
        rd(3'd4, rv); check("R10 no flag on rewrite", rv, 16'h0000);
        drive(1'b1, 1'b0, 3'd0, 16'd0);
        check("R6 match_a pulse", match_a, 1'b1);
        check("R7 b independent", match_b, 1'b0);
        edge_step();
        drive(1'b1, 1'b0, 3'd0, 16'd0);
        check("R6 single cycle", match_a, 1'b0);
        edge_step();
        rd(3'd4, rv); check("R7 flag A", rv, 16'h0002);
        drive(1'b1, 1'b0, 3'd0, 16'd0);
        check("R6 match_b pulse", match_b, 1'b1);
        edge_step();
        rd(3'd4, rv); check("R7 flag B", rv, 16'h0006);

        // R8 write-one-to-clear and set priority
        wr(3'd4, 16'h0000);
        rd(3'd4, rv); check("R8 zero write keeps", rv, 16'h0006);
        wr(3'd4, 16'h0002);
        rd(3'd4, rv); check("R8 clear A", rv, 16'h0004);
        wr(3'd1, exp_cnt);
        drive(1'b1, 1'b1, 3'd4, 16'h0002);
        check("R8 match during clear", match_a, 1'b1);
        edge_step();
        rd(3'd4, rv); check("R8 set wins", rv, 16'h0006);

        // R9 interrupt masking: rising edge, enable compare A only
        wr(3'd5, 16'h0005);
        check("R9 irq A", irq, 1'b1);
        wr(3'd4, 16'h0002);
        check("R9 irq masked B", irq, 1'b0);
        wr(3'd5, 16'h0009);
        check("R9 irq B", irq, 1'b1);
        wr(3'd4, 16'h0007);
        wr(3'd5, 16'h0003);               // rising, capture irq enabled

        // R4 capture with counter running
        wr(3'd0, 16'h0100);
        cap_in = 1'b1;
        tick(1'b1);
        tick(1'b1);
        snap = exp_cnt;
        rd(3'd4, rv); check("R4 not yet", rv, 16'h0000);
        tick(1'b1);
        rd(3'd4, rv); check("R4 flag", rv, 16'h0001);
        rd(3'd3, rv); check("R4 cap value", rv, snap);
        check("R9 irq cap", irq, 1'b1);
        wr(3'd4, 16'h0001);

        // R5 wrong polarity ignored
        cap_in = 1'b0;
        repeat (5) tick(1'b1);
        rd(3'd4, rv); check("R5 fall ignored flag", rv, 16'h0000);
        rd(3'd3, rv); check("R5 fall ignored cap", rv, snap);
        wr(3'd5, 16'h0000);               // select falling
        wr(3'd0, 16'h0ABC);
        cap_in = 1'b1;
        repeat (5) tick(1'b0);
        rd(3'd4, rv); check("R5 rise ignored", rv, 16'h0000);
        cap_in = 1'b0;
        repeat (3) tick(1'b0);
        rd(3'd4, rv); check("R5 falling flag", rv, 16'h0001);
        rd(3'd3, rv); check("R4 falling cap", rv, 16'h0ABC);
        wr(3'd4, 16'h0007);

        // R1 wrap with compare at top value
        wr(3'd0, 16'hFFFE);
        wr(3'd1, 16'hFFFF);
        drive(1'b1, 1'b0, 3'd0, 16'd0);
        check("R6 FFFE no match", match_a, 1'b0);
        edge_step();
        drive(1'b1, 1'b0, 3'd0, 16'd0);
        check("R6 FFFF match", match_a, 1'b1);
        edge_step();
        rd(3'd0, rv); check("R1 wrap", rv, 16'h0000);
        wr(3'd4, 16'h0007);

        // random phase: predicted match outputs
        wr(3'd1, exp_cnt + 16'd2);
        wr(3'd2, exp_cnt + 16'd3);
        for (int i = 0; i < 400; i++) begin
            logic en, w;
            logic [2:0] a;
            logic [15:0] d;
            en = 1'($urandom % 2);
            w  = (($urandom % 8) == 0);
            a  = 3'(1 + ($urandom % 2));
            if (($urandom % 4) == 0) a = 3'd0;
            d  = exp_cnt + 16'($urandom % 4);
            drive(en, w, a, d);
            check("R6 rand match_a", match_a,
                  pred_match(en, w && a == 3'd0, exp_cnt, exp_ca));
            check("R6 rand match_b", match_b,
                  pred_match(en, w && a == 3'd0, exp_cnt, exp_cb));
            edge_step();
        end
        rd(3'd0, rv); check("R1 rand count", rv, exp_cnt);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule